// File: doc/BRIEF.md
# I2C Slave Bridge with Byte Strobes

This block connects an I2C bus to a simple passive target, such as a register file, a small memory, a display controller or a sensor. It watches separate SDA and SCL inputs, oversampling them with a fast system clock. It drives a separate open-drain-style SDA output, where a value of 1 means the line is released.

Once the master sends the block's own 7-bit address, the block becomes either a receiver or a transmitter, depending on the direction bit that follows. In receive mode, every byte it takes in is handed to the target on an 8-bit output bus together with a one-clock write strobe. In transmit mode, the block requests every byte it sends with a one-clock read strobe and takes the byte from an 8-bit input bus.

The block works straight after reset and has nothing to configure. Bursts of any length and repeated STARTs are handled. Both bus lines are cleaned of short spikes before any edge is detected.

Top module: `i2cs_byte_bridge`

## Requirements
- R1: Out of reset, busSdaOut is 1 (released), tgtRd and tgtWr are 0 and tgtDataOut is 8'h00; no setup is needed before the first transfer.
- R2: After a START, the first byte is the 7-bit address, MSB first, followed by the direction bit (0 = master writes, 1 = master reads). When the address equals SLAVE_ADDR, the block pulls SDA low for the whole ninth clock.
- R3: A START whose address does not match leaves SDA released for the rest of the transfer, including all ACK slots, and produces no tgtWr or tgtRd until the next START.
- R4: In write mode, every received byte (MSB first) appears on tgtDataOut in the cycle tgtWr is high. tgtWr is high for exactly one clock per byte, and the byte is acknowledged with SDA low in its ninth clock. tgtDataOut changes only in a cycle where tgtWr is high.
- R5: In read mode, a one-clock tgtRd pulse requests each byte. tgtDataIn is taken on the clock edge that ends the tgtRd cycle, and the byte is shifted out MSB first. tgtRd and tgtWr are never high together.
- R6: When the master answers a transmitted byte with NACK (SDA high in the ninth clock), the burst ends: no further tgtRd is issued, and SDA stays released until the next START.
- R7: A repeated START in the middle of a transfer, with no STOP before it, restarts address reception. The new address and direction take effect.
- R8: A pulse on SDA or SCL lasting fewer than FILT_LEN system clocks has no effect: bits, START and STOP detection are unchanged.
- R9: busSdaOut changes only while the filtered SCL is low, DRIVE_DLY clocks after its falling edge.
- R10: A STOP returns the block to idle, and the next START with a matching address is served again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, all logic on its rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| busSdaIn | input | 1 | Sampled level of the SDA line |
| busSclIn | input | 1 | Sampled level of the SCL line |
| tgtDataIn | input | 8 | Byte from the target for transmission |
| busSdaOut | output | 1 | SDA drive, 0 pulls the line low, 1 releases it |
| tgtDataOut | output | 8 | Received byte for the target |
| tgtRd | output | 1 | One-clock request for the next transmit byte |
| tgtWr | output | 1 | One-clock strobe marking a received byte |

## Verification
The hardest case to reach from the pins is a repeated START that arrives just after the block has acknowledged a written byte. At that moment the block is still arming the next receive byte, and the new address has to reverse its direction. A second hard case is a spike that lands while a bit is being clocked in. The bench master builds both cases by hand. Its bit-level task can add a two-clock SCL pulse during the low phase and a two-clock SDA inversion during the high phase of every bit of a data byte. The repeated START is issued straight from the SCL-low state that follows a write acknowledge, and a read with a NACK-terminated byte follows it.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

  // What the datapath puts on SDA at a drive slot
  typedef enum logic [1:0] {
    SEL_REL  = 2'd0,  // release the line
    SEL_ACK  = 2'd1,  // pull low
    SEL_BIT  = 2'd2,  // present MSB of freshly loaded byte
    SEL_NEXT = 2'd3   // shift and present the following bit
  } sdaSel_e;

  typedef struct packed {
    logic    shiftIn;   // sample filtered SDA into shift register
    logic    loadTx;    // take target byte into shift register
    logic    capture;   // copy shift register to target data out
    logic    sdaUpd;    // update SDA drive this cycle
    sdaSel_e sdaSel;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_IGNORE
  } state_e;

endpackage

// File: rtl/i2cs_glitch_filter.sv
`timescale 1ns/1ps
module i2cs_glitch_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      syncQ   <= 2'b11;
      runCnt  <= '0;
      filtOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == filtOut) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_LEN - 1)) begin
        filtOut <= syncQ[1];
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_datapath.sv
`timescale 1ns/1ps
module i2cs_datapath
  import i2cs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  ctlStrobes_t ctl,
  input  logic        sdaFilt,
  input  logic [7:0]  tgtDataIn,
  output logic [7:0]  shiftByte,
  output logic [7:0]  tgtDataOut,
  output logic        busSdaOut
);
  logic [7:0] shiftReg;
  assign shiftByte = shiftReg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      shiftReg   <= '0;
      tgtDataOut <= '0;
      busSdaOut  <= 1'b1;
    end else begin
      if (ctl.shiftIn)
        shiftReg <= {shiftReg[6:0], sdaFilt};
      else if (ctl.loadTx)
        shiftReg <= tgtDataIn;
      else if (ctl.sdaUpd && ctl.sdaSel == SEL_NEXT)
        shiftReg <= {shiftReg[6:0], 1'b1};

      if (ctl.capture)
        tgtDataOut <= shiftReg;

      if (ctl.sdaUpd) begin
        case (ctl.sdaSel)
          SEL_REL:  busSdaOut <= 1'b1;
          SEL_ACK:  busSdaOut <= 1'b0;
          SEL_BIT:  busSdaOut <= shiftReg[7];
          SEL_NEXT: busSdaOut <= shiftReg[6];
          default:  busSdaOut <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_control.sv
`timescale 1ns/1ps
module i2cs_control
  import i2cs_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h2A,
  parameter int         DRIVE_DLY  = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclFilt,
  input  logic        sdaFilt,
  input  logic [7:0]  shiftByte,
  output ctlStrobes_t ctl,
  output logic        tgtRd,
  output logic        tgtWr
);
  // a read byte must be loaded before its first bit is driven
  localparam int DLY = (DRIVE_DLY < 2) ? 2 : DRIVE_DLY;
  localparam int DW  = $clog2(DLY + 1);

  state_e        state, stN;
  logic [3:0]    bitCnt, cntN;
  logic          rw, rwN, masterAck, ackN;
  logic          sclPrev, sdaPrev;
  logic          dlyRun;
  logic [DW-1:0] dlyCnt;
  logic          rdEv, capEv;

  wire sclRise = sclFilt & ~sclPrev;
  wire sclFall = ~sclFilt & sclPrev;
  wire startEv = sclFilt & sclPrev & sdaPrev & ~sdaFilt;
  wire stopEv  = sclFilt & sclPrev & ~sdaPrev & sdaFilt;
  wire slot    = dlyRun & (dlyCnt == DW'(DLY - 1));

  always_comb begin
    stN = state; cntN = bitCnt; rwN = rw; ackN = masterAck;
    rdEv = 1'b0; capEv = 1'b0;
    ctl = '0;
    ctl.sdaSel = SEL_REL;
    ctl.loadTx = tgtRd;
    if (startEv) begin
      stN = ST_ADDR; cntN = '0;
    end else if (stopEv) begin
      stN = ST_IDLE; cntN = '0;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            ctl.shiftIn = 1'b1;
            cntN = bitCnt + 4'd1;
          end
          if (slot && bitCnt == 4'd8) begin
            if (state == ST_RX) begin
              ctl.sdaUpd = 1'b1; ctl.sdaSel = SEL_ACK;
              ctl.capture = 1'b1; capEv = 1'b1;
              stN = ST_RX_ACK;
            end else if (shiftByte[7:1] == SLAVE_ADDR) begin
              ctl.sdaUpd = 1'b1; ctl.sdaSel = SEL_ACK;
              rwN = shiftByte[0];
              stN = ST_ADDR_ACK;
            end else begin
              stN = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall && rw) rdEv = 1'b1;
          if (slot) begin
            ctl.sdaUpd = 1'b1; cntN = '0;
            ctl.sdaSel = rw ? SEL_BIT : SEL_REL;
            stN = rw ? ST_TX : ST_RX;
          end
        end
        ST_RX_ACK: begin
          if (slot) begin
            ctl.sdaUpd = 1'b1; ctl.sdaSel = SEL_REL;
            cntN = '0; stN = ST_RX;
          end
        end
        ST_TX: begin
          if (sclRise) cntN = bitCnt + 4'd1;
          if (slot) begin
            ctl.sdaUpd = 1'b1;
            if (bitCnt < 4'd8) ctl.sdaSel = SEL_NEXT;
            else begin ctl.sdaSel = SEL_REL; stN = ST_TX_ACK; end
          end
        end
        ST_TX_ACK: begin
          if (sclRise) ackN = ~sdaFilt;
          if (sclFall) begin
            if (masterAck) rdEv = 1'b1;
            else stN = ST_IGNORE;
          end
          if (slot) begin
            ctl.sdaUpd = 1'b1; ctl.sdaSel = SEL_BIT;
            cntN = '0; stN = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= ST_IDLE; bitCnt <= '0; rw <= 1'b0; masterAck <= 1'b0;
      sclPrev <= 1'b1; sdaPrev <= 1'b1;
      dlyRun <= 1'b0; dlyCnt <= '0;
      tgtRd <= 1'b0; tgtWr <= 1'b0;
    end else begin
      state <= stN; bitCnt <= cntN; rw <= rwN; masterAck <= ackN;
      sclPrev <= sclFilt; sdaPrev <= sdaFilt;
      tgtRd <= rdEv; tgtWr <= capEv;
      if (sclFall) begin
        dlyRun <= 1'b1; dlyCnt <= '0;
      end else if (slot) begin
        dlyRun <= 1'b0;
      end else if (dlyRun) begin
        dlyCnt <= dlyCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_byte_bridge.sv
`timescale 1ns/1ps
module i2cs_byte_bridge
  import i2cs_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h2A,
  parameter int         FILT_LEN   = 3,
  parameter int         DRIVE_DLY  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busSdaIn,
  input  logic       busSclIn,
  input  logic [7:0] tgtDataIn,
  output logic       busSdaOut,
  output logic [7:0] tgtDataOut,
  output logic       tgtRd,
  output logic       tgtWr
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] rawLines, filtLines;
  logic              sdaFilt, sclFilt;
  logic [7:0]        shiftByte;
  ctlStrobes_t       ctl;

  assign rawLines = {busSclIn, busSdaIn};
  assign sdaFilt  = filtLines[0];
  assign sclFilt  = filtLines[1];

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2cs_glitch_filter #(.FILT_LEN(FILT_LEN)) filt_i (
      .clk(clk), .rst(rst), .rawIn(rawLines[g]), .filtOut(filtLines[g])
    );
  end

  i2cs_control #(.SLAVE_ADDR(SLAVE_ADDR), .DRIVE_DLY(DRIVE_DLY)) ctrl_i (
    .clk(clk), .rst(rst), .sclFilt(sclFilt), .sdaFilt(sdaFilt),
    .shiftByte(shiftByte), .ctl(ctl), .tgtRd(tgtRd), .tgtWr(tgtWr)
  );

  i2cs_datapath dp_i (
    .clk(clk), .rst(rst), .ctl(ctl), .sdaFilt(sdaFilt),
    .tgtDataIn(tgtDataIn), .shiftByte(shiftByte),
    .tgtDataOut(tgtDataOut), .busSdaOut(busSdaOut)
  );
endmodule

// File: rtl/i2cs_byte_bridge_chk.sv
`timescale 1ns/1ps
module i2cs_byte_bridge_chk (
  input logic       clk,
  input logic       rst,
  input logic       sclFilt,
  input logic       busSdaOut,
  input logic       tgtRd,
  input logic       tgtWr,
  input logic [7:0] tgtDataOut
);
  // R9: SDA drive moves only while filtered SCL is low
  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (busSdaOut != $past(busSdaOut)) |-> !sclFilt);

  // R4: write strobe lasts one clock
  a_r4_wr_single: assert property (@(posedge clk) disable iff (rst)
    tgtWr |=> !tgtWr);

  // R4: received byte changes only with its strobe
  a_r4_data_with_wr: assert property (@(posedge clk) disable iff (rst)
    (tgtDataOut != $past(tgtDataOut)) |-> tgtWr);

  // R5: read strobe lasts one clock
  a_r5_rd_single: assert property (@(posedge clk) disable iff (rst)
    tgtRd |=> !tgtRd);

  // R5: strobes are exclusive
  a_r5_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(tgtRd && tgtWr));
endmodule

bind i2cs_byte_bridge i2cs_byte_bridge_chk chk_i (
  .clk(clk), .rst(rst), .sclFilt(sclFilt), .busSdaOut(busSdaOut),
  .tgtRd(tgtRd), .tgtWr(tgtWr), .tgtDataOut(tgtDataOut)
);

// File: tb/i2cs_byte_bridge_tb_top.sv
`timescale 1ns/1ps
module i2cs_byte_bridge_tb_top;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0, rst = 1'b1;
  logic mSda = 1'b1, mScl = 1'b1;
  logic [7:0] tgtDataIn = 8'hA0;
  logic busSdaOut, tgtRd, tgtWr;
  logic [7:0] tgtDataOut;
  wire sdaBus = mSda & busSdaOut;

  int checks = 0, fails = 0;
  int wrCnt = 0, rdCnt = 0, r9Bad = 0;
  logic [7:0] wrLog [16];
  logic prevSda = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2cs_byte_bridge #(.SLAVE_ADDR(SLV), .FILT_LEN(3), .DRIVE_DLY(3)) dut_i (
    .clk(clk), .rst(rst), .busSdaIn(sdaBus), .busSclIn(mScl),
    .tgtDataIn(tgtDataIn), .busSdaOut(busSdaOut), .tgtDataOut(tgtDataOut),
    .tgtRd(tgtRd), .tgtWr(tgtWr)
  );

  // target model and monitors, all away from the active edge
  always @(negedge clk) begin
    if (tgtWr) begin wrLog[wrCnt[3:0]] = tgtDataOut; wrCnt++; end
    if (tgtRd) begin tgtDataIn = 8'hA0 + 8'(rdCnt); rdCnt++; end
    if (!rst && busSdaOut != prevSda && mScl) r9Bad++;
    prevSda = busSdaOut;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic b, input bit glitch, output logic seen);
    wq(10); mSda = b;
    if (glitch) begin wq(5); mScl = 1'b1; wq(2); mScl = 1'b0; wq(23); end
    else wq(30);
    mScl = 1'b1; wq(10);
    if (glitch) begin mSda = ~mSda; wq(2); mSda = ~mSda; wq(8); end
    else wq(10);
    seen = sdaBus;
    wq(20); mScl = 1'b0;
  endtask

  task automatic busStart();
    if (!mScl) begin wq(10); mSda = 1'b1; wq(30); mScl = 1'b1; wq(20); end
    mSda = 1'b0; wq(20); mScl = 1'b0;
  endtask

  task automatic busStop();
    wq(10); mSda = 1'b0; wq(30); mScl = 1'b1; wq(20); mSda = 1'b1; wq(40);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit glitch, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], glitch, s);
    clockBit(1'b1, 1'b0, ack);
  endtask

  task automatic recvByte(input logic ackBit, output logic [7:0] v);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin clockBit(1'b1, 1'b0, s); v = {v[6:0], s}; end
    clockBit(ackBit, 1'b0, s);
  endtask

  // {address byte, data byte, ack expected}
  localparam logic [16:0] VEC [5] = '{
    {{SLV, 1'b0}, 8'h5C, 1'b1},
    {8'h56,       8'h33, 1'b0},
    {{SLV, 1'b0}, 8'h00, 1'b1},
    {{SLV, 1'b0}, 8'hFF, 1'b1},
    {8'hAA,       8'h12, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual %0h expected %0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a, a2;
    logic [7:0] rb;
    int w0, r0;
    wq(5);
    // R1 reset state
    chk(busSdaOut == 1'b1, "R1 sda released", busSdaOut, 1);
    chk(tgtRd == 1'b0, "R1 rd idle", tgtRd, 0);
    chk(tgtWr == 1'b0, "R1 wr idle", tgtWr, 0);
    chk(tgtDataOut == 8'h00, "R1 dataOut", tgtDataOut, 0);
    rst = 1'b0; wq(20);

    // table: single-byte writes, matching and foreign addresses (R2 R3 R4 R10)
    for (int k = 0; k < 5; k++) begin
      w0 = wrCnt;
      busStart();
      sendByte(VEC[k][16:9], 1'b0, a);
      sendByte(VEC[k][8:1], 1'b0, a2);
      busStop();
      if (VEC[k][0]) begin
        chk(a == 1'b0, "R2/R10 address ack", a, 0);
        chk(a2 == 1'b0, "R4 data ack", a2, 0);
        chk(wrCnt == w0 + 1, "R4 one wr strobe", wrCnt - w0, 1);
        chk(wrLog[w0[3:0]] == VEC[k][8:1], "R4 written byte", wrLog[w0[3:0]], VEC[k][8:1]);
      end else begin
        chk(a == 1'b1 && a2 == 1'b1, "R3 no ack on foreign address", {a, a2}, 3);
        chk(wrCnt == w0, "R3 no wr strobe", wrCnt - w0, 0);
      end
    end

    // R4 burst write
    w0 = wrCnt;
    busStart(); sendByte({SLV, 1'b0}, 1'b0, a);
    sendByte(8'h11, 1'b0, a); sendByte(8'h22, 1'b0, a); sendByte(8'hC3, 1'b0, a2);
    busStop();
    chk(wrCnt == w0 + 3, "R4 burst strobe count", wrCnt - w0, 3);
    chk(wrLog[w0[3:0]] == 8'h11 && wrLog[4'(w0 + 2)] == 8'hC3, "R4 burst bytes",
        wrLog[4'(w0 + 2)], 8'hC3);

    // R5 R6 burst read ending in NACK
    r0 = rdCnt;
    busStart(); sendByte({SLV, 1'b1}, 1'b0, a);
    chk(a == 1'b0, "R2 read address ack", a, 0);
    recvByte(1'b0, rb); chk(rb == 8'hA0 + 8'(r0), "R5 read byte 0", rb, 8'hA0 + 8'(r0));
    recvByte(1'b0, rb); chk(rb == 8'hA1 + 8'(r0), "R5 read byte 1", rb, 8'hA1 + 8'(r0));
    recvByte(1'b1, rb); chk(rb == 8'hA2 + 8'(r0), "R5 read byte 2", rb, 8'hA2 + 8'(r0));
    chk(busSdaOut == 1'b1, "R6 released after nack", busSdaOut, 1);
    wq(200);
    chk(rdCnt == r0 + 3, "R6 no rd after nack", rdCnt - r0, 3);
    busStop();

    // R7 repeated start from write into read
    w0 = wrCnt; r0 = rdCnt;
    busStart(); sendByte({SLV, 1'b0}, 1'b0, a); sendByte(8'h3C, 1'b0, a);
    busStart(); sendByte({SLV, 1'b1}, 1'b0, a2);
    chk(a2 == 1'b0, "R7 ack after repeated start", a2, 0);
    recvByte(1'b1, rb);
    busStop();
    chk(wrLog[w0[3:0]] == 8'h3C && wrCnt == w0 + 1, "R7 write before restart",
        wrLog[w0[3:0]], 8'h3C);
    chk(rb == 8'hA0 + 8'(r0), "R7 read after restart", rb, 8'hA0 + 8'(r0));

    // R8 spikes on both lines during a data byte
    w0 = wrCnt;
    busStart(); sendByte({SLV, 1'b0}, 1'b0, a);
    sendByte(8'h96, 1'b1, a2);
    busStop();
    chk(a2 == 1'b0, "R8 ack despite spikes", a2, 0);
    chk(wrCnt == w0 + 1 && wrLog[w0[3:0]] == 8'h96, "R8 byte despite spikes",
        wrLog[w0[3:0]], 8'h96);

    // R9 drive moments
    chk(r9Bad == 0, "R9 sda change with scl high", r9Bad, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule